// File: doc/BRIEF.md
# Two-Rank Serial-to-Parallel Latch

This block turns a serial bit stream into a parallel word that updates only when asked. Its first rank is a chain of shift stages clocked by a shift clock. On every rising edge of that clock, a new bit enters at stage 0 and every other stage takes the value of the stage below it. Its second rank is a holding register with its own rising-edge storage clock. On each storage edge the holding register copies the whole chain in one step, so a host can shift a full word in and then show it on the outputs all at once.

An active-low clear empties the shift chain at once and holds it empty. The clear does not reach the holding register, so the outputs keep showing the last word captured. An active-low output enable controls whether the parallel bus drives. The bus comes out as a data word plus a drive flag. A build-time mode sets what the gated bus does when it is not driving: it either reads zero or floats at high impedance. A cascade output carries the top shift stage at all times, whatever the output enable does. Feeding it into the serial input of another instance makes a longer chain. When one clock drives both ranks, the holding register captures the chain as it stood before that edge, so it is always one shift behind.

Top module: `sipo_latch`

## Requirements
- R1: On each rising shift-clock edge with clear high, stage 0 takes `sin` and stage i takes the old stage i-1. The shift rank therefore becomes ((old << 1) | sin) truncated to WIDTH bits.
- R2: `cas_out` always equals the top shift stage (stage WIDTH-1). The output enable has no effect on it.
- R3: On each rising storage-clock edge, `par_data` takes the contents of the shift rank as they stood just before that edge.
- R4: While `clr_n` is low, every shift stage reads 0 straight away, without waiting for a clock, and shift-clock edges do not change them.
- R5: A low `clr_n` leaves `par_data` unchanged. The outputs keep the captured word until the next storage-clock edge.
- R6: `par_drive` is 1 exactly when `oe_n` is 0. While it is 1, `par_q` equals `par_data`. While it is 0, `par_q` reads all zeros in the default gated mode, or high impedance in tri-state mode, and `par_data` still holds the captured word.
- R7: Stage i appears on output bit i. After WIDTH shifts and a storage edge, the first bit shifted in is on bit WIDTH-1 and the last one is on bit 0.
- R8: When both clocks rise on the same edge, `par_data` takes the value from before the shift. The shift rank has already moved on by one bit.
- R9: Two instances chained from `cas_out` to `sin`, with shared clocks, take 2*WIDTH bits sent most significant first. After a shared storage edge, the downstream instance shows the upper WIDTH bits and the upstream instance shows the lower WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock, rising edge |
| rclk | input | 1 | Storage clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift rank, active low |
| sin | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Parallel output enable, active low |
| cas_out | output | 1 | Cascade output, copy of the top shift stage |
| par_data | output | WIDTH | Holding-register contents, always valid |
| par_drive | output | 1 | High when the parallel bus is driving |
| par_q | output | WIDTH | Gated parallel bus (zero or high impedance when not driving) |

## Verification
The checker watches the block on every clock edge. It confirms that each shift step moves the chain by one position with the serial bit at the bottom. It confirms that the cascade pin follows the stage below the top one a shift later, that each storage edge captures the chain exactly, that the chain reads zero under clear, and that a driving bus matches the held word. Some behaviours cannot be seen edge by edge and need the bench's scenarios. These are: the holding word surviving a clear, the full bit order of a complete word across every byte value, the one-shift lag under a shared clock, and a 16-bit word splitting correctly across two chained instances.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // How the gated parallel bus behaves while not driving.
  typedef enum logic {
    OUT_GATED    = 1'b0,  // bus reads zero when disabled
    OUT_TRISTATE = 1'b1   // bus floats when disabled
  } out_mode_e;
endpackage

// File: rtl/sipo_shift_rank.sv
module sipo_shift_rank #(
  parameter int WIDTH = 8
) (
  input  logic             sclk,
  input  logic             clr_n,
  input  logic             sin,
  output logic [WIDTH-1:0] stage_q,
  output logic             tail_q
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_d;

  // Next value: every stage takes its lower neighbour, stage 0 takes sin.
  assign stage_d = {stage_q[LAST-1:0], sin};

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // Cascade tap taken straight from the top stage, never gated.
  assign tail_q = stage_q[LAST];
endmodule

// File: rtl/sipo_store_rank.sv
module sipo_store_rank #(
  parameter int WIDTH = 8
) (
  input  logic             rclk,
  input  logic [WIDTH-1:0] load_d,
  output logic [WIDTH-1:0] hold_q
);
  // No reset: the clear must not reach this rank.
  always_ff @(posedge rclk) begin
    hold_q <= load_d;
  end
endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage #(
  parameter int                  WIDTH    = 8,
  parameter sipo_pkg::out_mode_e OUT_MODE = sipo_pkg::OUT_GATED
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] par_data,
  output logic             par_drive,
  output logic [WIDTH-1:0] par_q
);
  assign par_data  = hold_q;
  assign par_drive = ~oe_n;

  generate
    if (OUT_MODE == sipo_pkg::OUT_TRISTATE) begin : g_tri
      assign par_q = par_drive ? hold_q : 'z;
    end else begin : g_gate
      assign par_q = hold_q & {WIDTH{par_drive}};
    end
  endgenerate
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int                  WIDTH    = 8,
  parameter sipo_pkg::out_mode_e OUT_MODE = sipo_pkg::OUT_GATED
) (
  input  logic             sclk,
  input  logic             rclk,
  input  logic             clr_n,
  input  logic             sin,
  input  logic             oe_n,
  output logic             cas_out,
  output logic [WIDTH-1:0] par_data,
  output logic             par_drive,
  output logic [WIDTH-1:0] par_q
);
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;

  sipo_shift_rank #(.WIDTH(WIDTH)) u_shift (
    .sclk    (sclk),
    .clr_n   (clr_n),
    .sin     (sin),
    .stage_q (shift_q),
    .tail_q  (cas_out)
  );

  sipo_store_rank #(.WIDTH(WIDTH)) u_store (
    .rclk   (rclk),
    .load_d (shift_q),
    .hold_q (hold_q)
  );

  sipo_out_stage #(.WIDTH(WIDTH), .OUT_MODE(OUT_MODE)) u_out (
    .oe_n      (oe_n),
    .hold_q    (hold_q),
    .par_data  (par_data),
    .par_drive (par_drive),
    .par_q     (par_q)
  );
endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
  parameter int WIDTH = 8
) (
  input logic             sclk,
  input logic             rclk,
  input logic             clr_n,
  input logic             sin,
  input logic [WIDTH-1:0] shift_q,
  input logic             cas_out,
  input logic [WIDTH-1:0] par_data,
  input logic             par_drive,
  input logic [WIDTH-1:0] par_q
);
  AST_SHIFT_STEP: assert property (@(posedge sclk) disable iff (!clr_n)
    1'b1 |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(sin)}); // R1

  AST_CASCADE_TAP: assert property (@(posedge sclk) disable iff (!clr_n)
    1'b1 |=> cas_out == $past(shift_q[WIDTH-2])); // R2

  AST_STORE_CAPTURE: assert property (@(posedge rclk) disable iff (!clr_n)
    1'b1 |=> par_data == $past(shift_q)); // R3

  AST_CLEAR_EMPTY: assert property (@(posedge sclk)
    !clr_n |-> (shift_q == '0 && !cas_out)); // R4

  AST_BUS_DRIVE: assert property (@(posedge sclk) disable iff (!clr_n)
    par_drive |-> par_q == par_data); // R6
endmodule

bind sipo_latch sipo_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .sclk      (sclk),
  .rclk      (rclk),
  .clr_n     (clr_n),
  .sin       (sin),
  .shift_q   (shift_q),
  .cas_out   (cas_out),
  .par_data  (par_data),
  .par_drive (par_drive),
  .par_q     (par_q)
);

// File: tb/sipo_latch_test.sv
`timescale 1ns/1ps
module sipo_latch_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic sclk = 1'b0, rclk = 1'b0, clr_n = 1'b0, sin = 1'b0, oe_n = 1'b0;
  logic         cas_a, cas_b, drv_a, drv_b;
  logic [W-1:0] dat_a, dat_b, q_a, q_b;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  sipo_latch #(.WIDTH(W)) uut (
    .sclk(sclk), .rclk(rclk), .clr_n(clr_n), .sin(sin), .oe_n(oe_n),
    .cas_out(cas_a), .par_data(dat_a), .par_drive(drv_a), .par_q(q_a));

  sipo_latch #(.WIDTH(W)) uut_b (
    .sclk(sclk), .rclk(rclk), .clr_n(clr_n), .sin(cas_a), .oe_n(oe_n),
    .cas_out(cas_b), .par_data(dat_b), .par_drive(drv_b), .par_q(q_b));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sin = b; #1 sclk = 1'b1; #1 sclk = 1'b0; #1;
  endtask

  task automatic store;
    #1 rclk = 1'b1; #1 rclk = 1'b0; #1;
  endtask

  task automatic both_bit(input logic b);
    sin = b; #1 begin sclk = 1'b1; rclk = 1'b1; end
    #1 begin sclk = 1'b0; rclk = 1'b0; end #1;
  endtask

  task automatic do_clear;
    clr_n = 1'b0; #1 sclk = 1'b1; #1 sclk = 1'b0; #1 clr_n = 1'b1; #1;
  endtask

  task automatic load_byte(input logic [7:0] v);
    for (int j = 7; j >= 0; j--) shift_bit(v[j]);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      report();
    end
  end

  initial begin
    logic [7:0]  mdl;
    logic [15:0] w;
    // Reset state: clear held low, one shift edge, then a storage edge.
    #2 sclk = 1'b1; #1 sclk = 1'b0; #1;
    check("R4 cascade under clear", {15'd0, cas_a}, 16'd0);
    store();
    check("R3 stored empty chain", {8'd0, dat_a}, 16'd0);
    check("R6 drive flag with oe_n low", {15'd0, drv_a}, 16'd1);
    clr_n = 1'b1; #1;

    // Sweep every byte: R7 order, R2 cascade, R9 chained word.
    for (int v = 0; v < 256; v++) begin
      do_clear();
      mdl = 8'h00;
      for (int j = 7; j >= 0; j--) begin
        shift_bit(v[j]);
        mdl = {mdl[6:0], v[j]};
        if (v < 4 || v == 8'hB6) begin
          store();
          check("R1 step", {8'd0, dat_a}, {8'd0, mdl});
        end
      end
      store();
      check("R7 full word", {8'd0, dat_a}, v[15:0]);
      check("R2 cascade top", {15'd0, cas_a}, {15'd0, v[7]});
      w = {v[7:0] ^ 8'h5A, v[7:0]};
      do_clear();
      for (int j = 15; j >= 0; j--) shift_bit(w[j]);
      store();
      check("R9 low half", {8'd0, dat_a}, {8'd0, w[7:0]});
      check("R9 high half", {8'd0, dat_b}, {8'd0, w[15:8]});
    end

    // R4 / R5 clear behaviour.
    do_clear();
    load_byte(8'hFF);
    store();
    check("R3 all ones", {8'd0, dat_a}, 16'h00FF);
    clr_n = 1'b0; #1;
    check("R4 immediate clear", {15'd0, cas_a}, 16'd0);
    check("R5 hold during clear", {8'd0, dat_a}, 16'h00FF);
    shift_bit(1'b1);
    check("R4 shift ignored", {15'd0, cas_a}, 16'd0);
    clr_n = 1'b1; #1;
    check("R5 hold after clear", {8'd0, dat_a}, 16'h00FF);
    store();
    check("R4 chain emptied", {8'd0, dat_a}, 16'd0);

    // R6 output enable, R2 cascade unaffected.
    load_byte(8'hC3);
    store();
    oe_n = 1'b1; #1;
    check("R6 drive off", {15'd0, drv_a}, 16'd0);
    check("R6 gated bus", {8'd0, q_a}, 16'd0);
    check("R6 data kept", {8'd0, dat_a}, 16'h00C3);
    check("R2 cascade with oe_n high", {15'd0, cas_a}, 16'd1);
    oe_n = 1'b0; #1;
    check("R6 bus driven", {8'd0, q_a}, 16'h00C3);

    // R8 shared clock lag.
    do_clear();
    load_byte(8'hA5);
    store();
    both_bit(1'b1);
    check("R8 pre-edge capture", {8'd0, dat_a}, 16'h00A5);
    store();
    check("R8 shifted chain", {8'd0, dat_a}, 16'h004B);
    both_bit(1'b0);
    check("R8 second lag", {8'd0, dat_a}, 16'h004B);
    store();
    check("R8 second shift", {8'd0, dat_a}, 16'h0096);

    done = 1'b1;
    report();
  end
endmodule